// File: doc/BRIEF.md
# I2C Status Flag Controller

This block keeps the status flags of an I2C peripheral and updates them. The bus engine signals events with one-cycle pulses: byte count reached, STOP seen, NACK received, own address matched, received byte loaded and transmit byte taken. Software acts with one-cycle pulses as well: clear strobes, START and STOP requests, reads of the receive data register, writes to the transmit data register, and forced sets of the two transmit flags.

The block drives a 7-bit status word and one interrupt line for each flag, each line gated by its own enable. It also drives a transmit DMA request, and it tracks whether the transmit holding register still has data waiting. Every output is a register. The reset is synchronous and active high.

Top module: `i2c_flag_ctrl`

## Requirements
- R1: After reset, `status` is 7'b0000001 with only the transmit-empty flag set. `irq`, `tx_dma_req` and `tx_pending` are 0.
- R2: The status word layout is fixed. Bit 0 is transmit-empty, bit 1 transmit-interrupt, bit 2 receive-full, bit 3 address-match, bit 4 NACK, bit 5 STOP-seen and bit 6 transfer-complete.
- R3: Transfer-complete (bit 6) sets one cycle after `ev_count_done`. It clears one cycle after `sw_start` or `sw_stop`. `enable` has no effect on it.
- R4: STOP-seen, NACK and address-match (bits 5, 4, 3) set one cycle after `ev_stop`, `ev_nack` and `ev_addr_match`. Each clears one cycle after its own strobe: `clr_stop`, `clr_nack` or `clr_addr`.
- R5: While `enable` is low, bits 5, 4 and 3 are held at 0 from the next cycle on, and their events are ignored.
- R6: Receive-full (bit 2) sets one cycle after `ev_rx_load` and clears one cycle after `rd_rx`.
- R7: When a set event and a clearing action for the same flag arrive in one cycle, the flag ends up set. This covers bits 1 to 6.
- R8: `wr_tx` clears transmit-empty and sets `tx_pending`. `ev_tx_consume` or `force_tbe` sets transmit-empty and clears `tx_pending`. If `force_tbe` and `wr_tx` arrive together, the flag ends up set and nothing is pending. If `ev_tx_consume` and `wr_tx` arrive together, the flag ends up clear and data is pending.
- R9: Transmit-interrupt (bit 1) sets one cycle after a cycle in which `engine_ready` is high, transmit-empty is 1 and no `wr_tx` occurs. It clears one cycle after `wr_tx`.
- R10: `force_ti` sets transmit-interrupt one cycle later when `slave_mode` is 1. When `slave_mode` is 0, `force_ti` is ignored.
- R11: `irq[i]` equals `status[i]` AND `ien[i]`, where `ien[i]` is the value present in the cycle before the edge. `tx_dma_req` equals transmit-interrupt AND `tx_dma_en` under the same timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Peripheral enable; low clears the bus-event flags |
| ev_count_done | input | 1 | Engine: programmed byte count transferred |
| ev_stop | input | 1 | Engine: STOP condition seen |
| ev_nack | input | 1 | Engine: not-acknowledge received |
| ev_addr_match | input | 1 | Engine: own address matched |
| ev_rx_load | input | 1 | Engine: byte moved into receive data register |
| ev_tx_consume | input | 1 | Engine: took byte from transmit holding register |
| engine_ready | input | 1 | Engine ready to send the next byte |
| sw_start | input | 1 | Software START request |
| sw_stop | input | 1 | Software STOP request |
| clr_stop | input | 1 | Software clear of STOP-seen |
| clr_nack | input | 1 | Software clear of NACK |
| clr_addr | input | 1 | Software clear of address-match |
| rd_rx | input | 1 | Software read of receive data register |
| wr_tx | input | 1 | Software write of transmit data register |
| force_tbe | input | 1 | Software force of transmit-empty; discards pending data |
| force_ti | input | 1 | Software force of transmit-interrupt |
| slave_mode | input | 1 | Mode bit that allows `force_ti` |
| ien | input | 7 | Interrupt enable per status bit |
| tx_dma_en | input | 1 | Transmit DMA enable |
| status | output | 7 | Flag word |
| irq | output | 7 | Gated interrupt per flag |
| tx_dma_req | output | 1 | Transmit DMA request |
| tx_pending | output | 1 | Transmit holding register holds data |

## Verification
The collision of interest is an engine set event landing in the same cycle as a software clear of the same flag. Examples are `ev_stop` with `clr_stop`, `ev_rx_load` with `rd_rx`, and `ev_count_done` with `sw_start`. The bench drives both pulses on one falling edge and reads the status one edge later; it expects the flag to be set.

The transmit side is provoked in the same way. A write is paired with a consume, and separately with a forced empty. Each pairing is judged on both transmit-empty and `tx_pending`, against the outcomes listed in R8.

// File: rtl/i2c_flag_pkg.sv
package i2c_flag_pkg;
  localparam int NFLAG  = 7;
  localparam int F_TBE  = 0;
  localparam int F_TI   = 1;
  localparam int F_RBNE = 2;
  localparam int F_ADDR = 3;
  localparam int F_NACK = 4;
  localparam int F_STOP = 5;
  localparam int F_TC   = 6;
  localparam logic [NFLAG-1:0] FLAG_RST = 7'b0000001;
endpackage

// File: rtl/i2c_flag_cell.sv
module i2c_flag_cell #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  input  logic kill_i,
  output logic q_o,
  output logic d_o
);
  // kill beats everything; a set beats a plain clear
  always_comb begin
    if (kill_i)      d_o = 1'b0;
    else if (set_i)  d_o = 1'b1;
    else if (clr_i)  d_o = 1'b0;
    else             d_o = q_o;
  end

  always_ff @(posedge clk) begin
    if (rst) q_o <= RST_VAL;
    else     q_o <= d_o;
  end

  p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (set_i && !kill_i) |=> q_o);
  p_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !q_o);
  p_kill_r5: assert property (@(posedge clk) disable iff (rst)
    kill_i |=> !q_o);
endmodule

// File: rtl/i2c_tx_hold.sv
module i2c_tx_hold (
  input  logic clk,
  input  logic rst,
  input  logic wr_i,
  input  logic consume_i,
  input  logic discard_i,
  output logic valid_o
);
  always_ff @(posedge clk) begin
    if (rst)            valid_o <= 1'b0;
    else if (discard_i) valid_o <= 1'b0;
    else if (wr_i)      valid_o <= 1'b1;
    else if (consume_i) valid_o <= 1'b0;
  end

  p_discard_r8: assert property (@(posedge clk) disable iff (rst)
    discard_i |=> !valid_o);
  p_refill_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_i && !discard_i) |=> valid_o);
endmodule

// File: rtl/i2c_flag_out.sv
module i2c_flag_out #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] flag_d,
  input  logic [N-1:0] ien,
  input  logic         ti_d,
  input  logic         dma_en,
  input  logic [N-1:0] status_q,
  input  logic         ti_q,
  output logic [N-1:0] irq,
  output logic         dma_req
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq     <= '0;
      dma_req <= 1'b0;
    end else begin
      irq     <= flag_d & ien;
      dma_req <= ti_d & dma_en;
    end
  end

  p_irq_gate_r11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == (status_q & $past(ien))));
  p_dma_gate_r11: assert property (@(posedge clk) disable iff (rst)
    dma_req |-> ti_q);
endmodule

// File: rtl/i2c_flag_ctrl.sv
module i2c_flag_ctrl
  import i2c_flag_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             ev_count_done,
  input  logic             ev_stop,
  input  logic             ev_nack,
  input  logic             ev_addr_match,
  input  logic             ev_rx_load,
  input  logic             ev_tx_consume,
  input  logic             engine_ready,
  input  logic             sw_start,
  input  logic             sw_stop,
  input  logic             clr_stop,
  input  logic             clr_nack,
  input  logic             clr_addr,
  input  logic             rd_rx,
  input  logic             wr_tx,
  input  logic             force_tbe,
  input  logic             force_ti,
  input  logic             slave_mode,
  input  logic [NFLAG-1:0] ien,
  input  logic             tx_dma_en,
  output logic [NFLAG-1:0] status,
  output logic [NFLAG-1:0] irq,
  output logic             tx_dma_req,
  output logic             tx_pending
);
  logic [NFLAG-1:0] set_v, clr_v, kill_v, flag_d;

  always_comb begin
    set_v  = '0;
    clr_v  = '0;
    kill_v = '0;
    set_v[F_TBE]  = force_tbe | (ev_tx_consume & ~wr_tx);
    clr_v[F_TBE]  = wr_tx;
    set_v[F_TI]   = (engine_ready & status[F_TBE] & ~wr_tx) | (force_ti & slave_mode);
    clr_v[F_TI]   = wr_tx;
    set_v[F_RBNE] = ev_rx_load;
    clr_v[F_RBNE] = rd_rx;
    set_v[F_ADDR] = ev_addr_match;
    clr_v[F_ADDR] = clr_addr;
    kill_v[F_ADDR] = ~enable;
    set_v[F_NACK] = ev_nack;
    clr_v[F_NACK] = clr_nack;
    kill_v[F_NACK] = ~enable;
    set_v[F_STOP] = ev_stop;
    clr_v[F_STOP] = clr_stop;
    kill_v[F_STOP] = ~enable;
    set_v[F_TC]   = ev_count_done;
    clr_v[F_TC]   = sw_start | sw_stop;
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    i2c_flag_cell #(.RST_VAL(FLAG_RST[i])) u_cell (
      .clk   (clk),
      .rst   (rst),
      .set_i (set_v[i]),
      .clr_i (clr_v[i]),
      .kill_i(kill_v[i]),
      .q_o   (status[i]),
      .d_o   (flag_d[i])
    );
  end

  i2c_tx_hold u_hold (
    .clk      (clk),
    .rst      (rst),
    .wr_i     (wr_tx),
    .consume_i(ev_tx_consume),
    .discard_i(force_tbe),
    .valid_o  (tx_pending)
  );

  i2c_flag_out #(.N(NFLAG)) u_out (
    .clk     (clk),
    .rst     (rst),
    .flag_d  (flag_d),
    .ien     (ien),
    .ti_d    (flag_d[F_TI]),
    .dma_en  (tx_dma_en),
    .status_q(status),
    .ti_q    (status[F_TI]),
    .irq     (irq),
    .dma_req (tx_dma_req)
  );

  p_tbe_vs_pending_r8: assert property (@(posedge clk) disable iff (rst)
    status[F_TBE] == !tx_pending);
  p_force_ti_r10: assert property (@(posedge clk) disable iff (rst)
    (force_ti && slave_mode) |=> status[F_TI]);
  p_force_ti_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    (!status[F_TI] && force_ti && !slave_mode && !engine_ready) |=> !status[F_TI]);
  p_disabled_r5: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (status[F_STOP:F_ADDR] == 3'b000));
  p_wr_clears_ti_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_tx && !(force_ti && slave_mode)) |=> !status[F_TI]);
endmodule

// File: tb/i2c_flag_ctrl_tb.sv
module i2c_flag_ctrl_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 0, ev_count_done = 0, ev_stop = 0, ev_nack = 0, ev_addr_match = 0;
  logic ev_rx_load = 0, ev_tx_consume = 0, engine_ready = 0, sw_start = 0, sw_stop = 0;
  logic clr_stop = 0, clr_nack = 0, clr_addr = 0, rd_rx = 0, wr_tx = 0;
  logic force_tbe = 0, force_ti = 0, slave_mode = 0, tx_dma_en = 0;
  logic [6:0] ien = '0;
  logic [6:0] status, irq;
  logic tx_dma_req, tx_pending;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  i2c_flag_ctrl u_dut (
    .clk(clk), .rst(rst), .enable(enable), .ev_count_done(ev_count_done),
    .ev_stop(ev_stop), .ev_nack(ev_nack), .ev_addr_match(ev_addr_match),
    .ev_rx_load(ev_rx_load), .ev_tx_consume(ev_tx_consume), .engine_ready(engine_ready),
    .sw_start(sw_start), .sw_stop(sw_stop), .clr_stop(clr_stop), .clr_nack(clr_nack),
    .clr_addr(clr_addr), .rd_rx(rd_rx), .wr_tx(wr_tx), .force_tbe(force_tbe),
    .force_ti(force_ti), .slave_mode(slave_mode), .ien(ien), .tx_dma_en(tx_dma_en),
    .status(status), .irq(irq), .tx_dma_req(tx_dma_req), .tx_pending(tx_pending)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // drop all one-cycle pulses
  task automatic idle();
    ev_count_done = 0; ev_stop = 0; ev_nack = 0; ev_addr_match = 0; ev_rx_load = 0;
    ev_tx_consume = 0; sw_start = 0; sw_stop = 0; clr_stop = 0; clr_nack = 0;
    clr_addr = 0; rd_rx = 0; wr_tx = 0; force_tbe = 0; force_ti = 0;
  endtask

  task automatic t_reset();
    chk_eq("R1 status", {25'd0, status}, 32'h01);
    chk_eq("R1 irq", {25'd0, irq}, 32'h0);
    chk_eq("R1 dma", {31'd0, tx_dma_req}, 32'h0);
    chk_eq("R1 pending", {31'd0, tx_pending}, 32'h0);
  endtask

  task automatic t_tc();
    ev_count_done = 1; step(); idle();
    chk_eq("R3 tc set", {25'd0, status}, 32'h41);
    enable = 0; step(); enable = 1;
    chk_eq("R3 tc ignores enable", {31'd0, status[6]}, 32'h1);
    sw_start = 1; step(); idle();
    chk_eq("R3 tc clr start", {31'd0, status[6]}, 32'h0);
    ev_count_done = 1; step(); idle();
    sw_stop = 1; step(); idle();
    chk_eq("R3 tc clr stop", {31'd0, status[6]}, 32'h0);
  endtask

  task automatic t_events();
    ev_stop = 1; step(); idle();
    chk_eq("R2 R4 stop bit5", {25'd0, status}, 32'h21);
    clr_stop = 1; step(); idle();
    chk_eq("R4 stop clr", {25'd0, status}, 32'h01);
    ev_nack = 1; step(); idle();
    chk_eq("R2 R4 nack bit4", {25'd0, status}, 32'h11);
    clr_nack = 1; step(); idle();
    chk_eq("R4 nack clr", {25'd0, status}, 32'h01);
    ev_addr_match = 1; step(); idle();
    chk_eq("R2 R4 addr bit3", {25'd0, status}, 32'h09);
    clr_addr = 1; step(); idle();
    chk_eq("R4 addr clr", {25'd0, status}, 32'h01);
  endtask

  task automatic t_disable();
    ev_stop = 1; ev_nack = 1; ev_addr_match = 1; step(); idle();
    chk_eq("R5 preset", {25'd0, status}, 32'h39);
    enable = 0; step();
    chk_eq("R5 disable clears", {25'd0, status}, 32'h01);
    ev_stop = 1; ev_nack = 1; ev_addr_match = 1; step(); idle();
    chk_eq("R5 events ignored", {25'd0, status}, 32'h01);
    enable = 1; step();
  endtask

  task automatic t_rx();
    ev_rx_load = 1; step(); idle();
    chk_eq("R2 R6 rbne bit2", {25'd0, status}, 32'h05);
    rd_rx = 1; step(); idle();
    chk_eq("R6 rbne clr", {25'd0, status}, 32'h01);
  endtask

  task automatic t_collide();
    ev_stop = 1; clr_stop = 1; ev_rx_load = 1; rd_rx = 1; ev_count_done = 1; sw_start = 1;
    step(); idle();
    chk_eq("R7 set wins", {25'd0, status}, 32'h65);
    clr_stop = 1; rd_rx = 1; sw_stop = 1; step(); idle();
    chk_eq("R7 cleanup", {25'd0, status}, 32'h01);
  endtask

  task automatic t_tx();
    wr_tx = 1; step(); idle();
    chk_eq("R8 write", {30'd0, status[0], tx_pending}, 32'h1);
    ev_tx_consume = 1; step(); idle();
    chk_eq("R8 consume", {30'd0, status[0], tx_pending}, 32'h2);
    wr_tx = 1; step(); idle();
    force_tbe = 1; step(); idle();
    chk_eq("R8 force empty", {30'd0, status[0], tx_pending}, 32'h2);
    wr_tx = 1; force_tbe = 1; step(); idle();
    chk_eq("R8 force beats write", {30'd0, status[0], tx_pending}, 32'h2);
    wr_tx = 1; step(); idle();
    wr_tx = 1; ev_tx_consume = 1; step(); idle();
    chk_eq("R8 write beats consume", {30'd0, status[0], tx_pending}, 32'h1);
    ev_tx_consume = 1; step(); idle();
    chk_eq("R8 drained", {30'd0, status[0], tx_pending}, 32'h2);
  endtask

  task automatic t_ti();
    engine_ready = 1; step(); engine_ready = 0;
    chk_eq("R9 ti set", {25'd0, status}, 32'h03);
    wr_tx = 1; step(); idle();
    chk_eq("R9 ti clr by write", {25'd0, status}, 32'h00);
    engine_ready = 1; step(); engine_ready = 0;
    chk_eq("R9 no ti while full", {31'd0, status[1]}, 32'h0);
    ev_tx_consume = 1; step(); idle();
    chk_eq("R9 empty not ready", {25'd0, status}, 32'h01);
  endtask

  task automatic t_force_ti();
    slave_mode = 0; force_ti = 1; step(); idle();
    chk_eq("R10 force ignored", {31'd0, status[1]}, 32'h0);
    slave_mode = 1; force_ti = 1; step(); idle();
    chk_eq("R10 force sets", {31'd0, status[1]}, 32'h1);
    wr_tx = 1; force_ti = 1; step(); idle();
    chk_eq("R10 R7 force vs write", {31'd0, status[1]}, 32'h1);
    wr_tx = 1; step(); idle();
    chk_eq("R9 write clears ti", {31'd0, status[1]}, 32'h0);
    ev_tx_consume = 1; slave_mode = 0; step(); idle();
  endtask

  task automatic t_irq();
    ien = 7'h7F; step();
    chk_eq("R11 tbe irq", {25'd0, irq}, 32'h01);
    ev_rx_load = 1; step(); idle();
    chk_eq("R11 rbne irq", {25'd0, irq}, 32'h05);
    ien = 7'h7B; step();
    chk_eq("R11 gated off", {25'd0, irq}, 32'h01);
    tx_dma_en = 1; slave_mode = 1; force_ti = 1; step(); idle();
    chk_eq("R11 dma req", {31'd0, tx_dma_req}, 32'h1);
    chk_eq("R11 ti irq", {31'd0, irq[1]}, 32'h1);
    tx_dma_en = 0; step();
    chk_eq("R11 dma off", {31'd0, tx_dma_req}, 32'h0);
    rd_rx = 1; step(); idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst = 0;
    step();
    t_reset();
    enable = 1;
    t_tc();
    t_events();
    t_disable();
    t_rx();
    t_collide();
    t_tx();
    t_ti();
    t_force_ti();
    t_irq();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule